// File: doc/BRIEF.md
# Dual Multiplier Add/Subtract Unit

The block multiplies two operand pairs in parallel and merges the two products in one adder that can add or subtract at run time. Each operand carries its own signed/unsigned control. Before the products reach the adder, each one can be rounded to the Q1.15 grid and clamped to the Q1.15 range. The adder output can also be rounded to that grid. A saturation flag for each multiplier leaves the block in the same cycle as the result it belongs to.

Operands, sign, round and saturate controls are captured in an input register. Products go into a pipeline register, and the combined value goes into an output register. A result is therefore due three clock edges after its operands, provided the clock enable is high. The add/subtract select and the output-round enable travel through their own control pipeline, one or two registers deep, which is set by a parameter. A shift chain can replace the first operand pair with values from a neighbouring block. The first pair's input register is driven back out so the next block in a chain can use it.

Top module: `dual_mult_addsub`

## Requirements
- R1: With `ena` held high, `result_o` equals P0 + P1 or P0 − P1 (two's complement, 2W+3 bits) three rising edges after the operands are presented. A new operand set may enter on every edge.
- R2: `a_signed_i` makes both A operands two's complement, and `b_signed_i` does the same for both B operands. When a control is low, its operands are unsigned. All four combinations are valid.
- R3: `sub_i` = 1 subtracts product 1 from product 0. With `CTL_STAGES` = 2, `sub_i` and `out_rnd_i` are sampled together with the operands. With `CTL_STAGES` = 1, they are sampled one edge after the operands.
- R4: When `rnd_en_i` is 1, each product has 2^14 added and bits [14:0] cleared, so that bit 15 is the Q1.15 LSB.
- R5: When `sat_en_i` is 1, a product above 32767·2^15 after rounding is clamped to that value, and one below −32768·2^15 is clamped to that value. The multiplier's flag (`sat0_o` / `sat1_o`) is raised in the same cycle as the result that used the clamped product.
- R6: A saturation flag stays low when `sat_en_i` was 0 for that operand set, or when the product was in range.
- R7: When `out_rnd_i` is 1, the adder output has 2^14 added and bits [14:0] cleared before it is registered.
- R8: `chain_a_o` / `chain_b_o` show the first pair's input register one edge after capture. When `chain_sel_i` is 1, that register takes `chain_a_i` / `chain_b_i` in place of `a0_i` / `b0_i`.
- R9: `aclr` high clears every register at once, without waiting for a clock edge. All outputs then read zero.
- R10: When `ena` is low, every stage holds its value, and all outputs stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| aclr | input | 1 | Asynchronous clear, active high |
| ena | input | 1 | Clock enable for all stages |
| a0_i | input | W | Multiplier 0 operand A |
| b0_i | input | W | Multiplier 0 operand B |
| a1_i | input | W | Multiplier 1 operand A |
| b1_i | input | W | Multiplier 1 operand B |
| a_signed_i | input | 1 | A operands are two's complement |
| b_signed_i | input | 1 | B operands are two's complement |
| chain_sel_i | input | 1 | Take multiplier 0 operands from the shift chain |
| chain_a_i | input | W | Shift-chain A input |
| chain_b_i | input | W | Shift-chain B input |
| chain_a_o | output | W | Registered multiplier 0 A operand, to the next block |
| chain_b_o | output | W | Registered multiplier 0 B operand, to the next block |
| rnd_en_i | input | 1 | Round products to Q1.15 |
| sat_en_i | input | 1 | Saturate products to the Q1.15 range |
| sub_i | input | 1 | 1 = P0 − P1, 0 = P0 + P1 |
| out_rnd_i | input | 1 | Round the adder output to Q1.15 |
| result_o | output | 2W+3 | Combined result, two's complement |
| sat0_o | output | 1 | Multiplier 0 product was clamped |
| sat1_o | output | 1 | Multiplier 1 product was clamped |

## Verification
`result_o` and both saturation flags are due three rising edges after the operands are driven. The chain outputs are due one edge after. The table walk drives a new vector on every falling edge and compares the vector from three falling edges earlier, so back-to-back operand sets exercise the full pipeline. A second instance with a one-deep control pipeline receives the same stream. Its expected value takes the add/subtract and round controls from the vector one slot later. The directed tests wait the exact number of edges before they sample. The clear test samples between edges, with no edge after `aclr` rises.

// File: rtl/dual_mult_addsub.sv
module dual_mult_addsub #(
  parameter int W          = 18,
  parameter int FRAC       = 15,
  parameter int CTL_STAGES = 2
) (
  input  logic             clk,
  input  logic             aclr,
  input  logic             ena,
  input  logic [W-1:0]     a0_i,
  input  logic [W-1:0]     b0_i,
  input  logic [W-1:0]     a1_i,
  input  logic [W-1:0]     b1_i,
  input  logic             a_signed_i,
  input  logic             b_signed_i,
  input  logic             chain_sel_i,
  input  logic [W-1:0]     chain_a_i,
  input  logic [W-1:0]     chain_b_i,
  output logic [W-1:0]     chain_a_o,
  output logic [W-1:0]     chain_b_o,
  input  logic             rnd_en_i,
  input  logic             sat_en_i,
  input  logic             sub_i,
  input  logic             out_rnd_i,
  output logic [2*W+2:0]   result_o,
  output logic             sat0_o,
  output logic             sat1_o
);
  localparam int PW = 2*W + 2;
  localparam int RW = PW + 1;
  localparam logic signed [PW-1:0] PMAX  = (PW'(1) << (2*FRAC)) - (PW'(1) << FRAC);
  localparam logic signed [PW-1:0] PMIN  = -(PW'(1) << (2*FRAC));
  localparam logic signed [PW-1:0] PHALF = PW'(1) << (FRAC-1);
  localparam logic signed [PW-1:0] PLOW  = (PW'(1) << FRAC) - PW'(1);
  localparam logic signed [RW-1:0] RHALF = RW'(1) << (FRAC-1);
  localparam logic signed [RW-1:0] RLOW  = (RW'(1) << FRAC) - RW'(1);

  logic [W-1:0] a0_q, b0_q, a1_q, b1_q;
  logic         as_q, bs_q, rnd_q, sat_q;
  logic signed [PW-1:0] p0_q, p1_q;
  logic         f0_q, f1_q;
  logic [1:0]   ctl_q [CTL_STAGES];
  logic signed [RW-1:0] sum, sum_r;

  function automatic logic [PW:0] scale(input logic [W-1:0] a, input logic [W-1:0] b,
                                        input logic as, input logic bs,
                                        input logic rnd, input logic sat);
    logic signed [PW-1:0] p;
    logic f;
    p = PW'($signed({as & a[W-1], a})) * PW'($signed({bs & b[W-1], b}));
    f = 1'b0;
    if (rnd) p = (p + PHALF) & ~PLOW;
    if (sat && p > PMAX) begin
      p = PMAX;
      f = 1'b1;
    end else if (sat && p < PMIN) begin
      p = PMIN;
      f = 1'b1;
    end
    return {f, p};
  endfunction

  always_ff @(posedge clk or posedge aclr) begin
    if (aclr) begin
      a0_q <= '0; b0_q <= '0; a1_q <= '0; b1_q <= '0;
      as_q <= 1'b0; bs_q <= 1'b0; rnd_q <= 1'b0; sat_q <= 1'b0;
    end else if (ena) begin
      a0_q  <= chain_sel_i ? chain_a_i : a0_i;
      b0_q  <= chain_sel_i ? chain_b_i : b0_i;
      a1_q  <= a1_i;
      b1_q  <= b1_i;
      as_q  <= a_signed_i;
      bs_q  <= b_signed_i;
      rnd_q <= rnd_en_i;
      sat_q <= sat_en_i;
    end
  end

  always_ff @(posedge clk or posedge aclr) begin
    if (aclr) begin
      p0_q <= '0; p1_q <= '0; f0_q <= 1'b0; f1_q <= 1'b0;
    end else if (ena) begin
      {f0_q, p0_q} <= scale(a0_q, b0_q, as_q, bs_q, rnd_q, sat_q);
      {f1_q, p1_q} <= scale(a1_q, b1_q, as_q, bs_q, rnd_q, sat_q);
    end
  end

  always_ff @(posedge clk or posedge aclr) begin
    if (aclr) begin
      for (int i = 0; i < CTL_STAGES; i++) ctl_q[i] <= '0;
    end else if (ena) begin
      ctl_q[0] <= {out_rnd_i, sub_i};
      for (int i = 1; i < CTL_STAGES; i++) ctl_q[i] <= ctl_q[i-1];
    end
  end

  assign sum   = ctl_q[CTL_STAGES-1][0] ? RW'(p0_q) - RW'(p1_q) : RW'(p0_q) + RW'(p1_q);
  assign sum_r = ctl_q[CTL_STAGES-1][1] ? (sum + RHALF) & ~RLOW : sum;

  always_ff @(posedge clk or posedge aclr) begin
    if (aclr) begin
      result_o <= '0; sat0_o <= 1'b0; sat1_o <= 1'b0;
    end else if (ena) begin
      result_o <= sum_r;
      sat0_o   <= f0_q;
      sat1_o   <= f1_q;
    end
  end

  assign chain_a_o = a0_q;
  assign chain_b_o = b0_q;

  // R10
  freeze_chk: assert property (@(posedge clk) disable iff (aclr)
    !ena |=> $stable(result_o) && $stable(sat0_o) && $stable(sat1_o));

  // R8
  chain_chk: assert property (@(posedge clk) disable iff (aclr)
    ena |=> chain_a_o == $past(chain_sel_i ? chain_a_i : a0_i) &&
            chain_b_o == $past(chain_sel_i ? chain_b_i : b0_i));

  // R7
  out_rnd_chk: assert property (@(posedge clk) disable iff (aclr)
    (ena && ctl_q[CTL_STAGES-1][1]) |=> result_o[FRAC-1:0] == '0);

  // R5
  sat_val_chk: assert property (@(posedge clk) disable iff (aclr)
    (f0_q || f1_q) |-> ((!f0_q || p0_q == PMAX || p0_q == PMIN) &&
                        (!f1_q || p1_q == PMAX || p1_q == PMIN)));

  // R6
  sat_off_chk: assert property (@(posedge clk) disable iff (aclr)
    (ena && !sat_q) |=> (!f0_q && !f1_q));

  // R9
  clr_chk: assert property (@(posedge clk)
    aclr |-> (result_o == '0 && !sat0_o && !sat1_o && chain_a_o == '0 && chain_b_o == '0));
endmodule

// File: tb/dual_mult_addsub_bench.sv
`timescale 1ns/1ps
module dual_mult_addsub_bench;
  localparam int W = 18;
  localparam int RW = 2*W + 3;

  typedef struct packed {
    logic [W-1:0] a0, b0, a1, b1;
    logic as, bs, sub, rnd, sat, ornd;
    logic [3:0] req;
  } vec_t;

  localparam int N = 14;
  localparam vec_t TBL [N] = '{
    '{18'd3, 18'd5, 18'd2, 18'd7, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd1},             // R1
    '{18'h3FFFF, 18'd5, 18'd2, 18'h3FFFE, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'd2},     // R2 ss
    '{18'h3FFFF, 18'd5, 18'd2, 18'h3FFFE, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'd2},     // R2 us
    '{18'h3FFFF, 18'd5, 18'd2, 18'h3FFFE, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'd2},     // R2 su
    '{18'h3FFFF, 18'd5, 18'd2, 18'h3FFFE, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'd2},     // R2 uu
    '{18'd1000, 18'd2000, 18'd300, 18'h3FE70, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 4'd3}, // R3
    '{18'd12345, 18'd3, 18'd7, 18'h3FFF0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 4'd4},    // R4
    '{18'h38000, 18'h38000, 18'd0, 18'd0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 4'd5},    // R5 high clamp
    '{18'h38000, 18'h08000, 18'h30000, 18'h08000, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 4'd5}, // R5 low clamp
    '{18'h38000, 18'h38000, 18'h30000, 18'h08000, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'd6}, // R6 disabled
    '{18'd300, 18'd200, 18'd9, 18'd7, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 4'd7},        // R7
    '{18'h3FFFF, 18'h3FFFF, 18'h3FFFF, 18'h3FFFF, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 4'd1}, // R1 max
    '{18'h37FFF, 18'h37FFF, 18'd16385, 18'd16385, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 4'd5}, // R5 with R4
    '{18'd77, 18'h3FF00, 18'd0, 18'd5, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 4'd3}         // R3
  };

  logic clk = 1'b0, aclr = 1'b1, ena = 1'b1;
  logic [W-1:0] a0, b0, a1, b1, ca, cb;
  logic as_i, bs_i, csel, rnd, sat, sub, ornd;
  logic [W-1:0] cao, cbo, cao2, cbo2;
  logic [RW-1:0] res, res2;
  logic s0, s1, s0b, s1b;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  dual_mult_addsub u_dual_mult_addsub (
    .clk(clk), .aclr(aclr), .ena(ena), .a0_i(a0), .b0_i(b0), .a1_i(a1), .b1_i(b1),
    .a_signed_i(as_i), .b_signed_i(bs_i), .chain_sel_i(csel), .chain_a_i(ca), .chain_b_i(cb),
    .chain_a_o(cao), .chain_b_o(cbo), .rnd_en_i(rnd), .sat_en_i(sat), .sub_i(sub),
    .out_rnd_i(ornd), .result_o(res), .sat0_o(s0), .sat1_o(s1));

  dual_mult_addsub #(.CTL_STAGES(1)) u_dual_mult_addsub_c1 (
    .clk(clk), .aclr(aclr), .ena(ena), .a0_i(a0), .b0_i(b0), .a1_i(a1), .b1_i(b1),
    .a_signed_i(as_i), .b_signed_i(bs_i), .chain_sel_i(csel), .chain_a_i(ca), .chain_b_i(cb),
    .chain_a_o(cao2), .chain_b_o(cbo2), .rnd_en_i(rnd), .sat_en_i(sat), .sub_i(sub),
    .out_rnd_i(ornd), .result_o(res2), .sat0_o(s0b), .sat1_o(s1b));

  function automatic longint opv(logic [W-1:0] x, logic sg);
    longint v = longint'(x);
    if (sg && x[W-1]) v = v - (longint'(1) << W);
    return v;
  endfunction

  function automatic longint prod(logic [W-1:0] a, logic [W-1:0] b, logic as, logic bs,
                                  logic r, logic s, output logic f);
    longint p = opv(a, as) * opv(b, bs);
    f = 1'b0;
    if (r) p = (p + 16384) & ~longint'(32767);
    if (s && p > 32767 * 32768) begin p = 32767 * 32768; f = 1'b1; end
    else if (s && p < -32768 * 32768) begin p = -32768 * 32768; f = 1'b1; end
    return p;
  endfunction

  function automatic longint model(vec_t v, logic sb, logic orn, output logic f0, output logic f1);
    longint p0 = prod(v.a0, v.b0, v.as, v.bs, v.rnd, v.sat, f0);
    longint p1 = prod(v.a1, v.b1, v.as, v.bs, v.rnd, v.sat, f1);
    longint s = sb ? p0 - p1 : p0 + p1;
    if (orn) s = (s + 16384) & ~longint'(32767);
    return s;
  endfunction

  task automatic check(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(vec_t v);
    a0 = v.a0; b0 = v.b0; a1 = v.a1; b1 = v.b1; as_i = v.as; bs_i = v.bs;
    sub = v.sub; rnd = v.rnd; sat = v.sat; ornd = v.ornd;
  endtask

  function automatic longint rv(logic [RW-1:0] r);
    return longint'($signed(r));
  endfunction

  initial begin
    vec_t z, v, nx;
    longint e, e2;
    logic f0, f1, g0, g1;
    z = '0;
    drive(z); csel = 1'b0; ca = '0; cb = '0;
    #1;
    // R9 reset state
    check(res == '0 && !s0 && !s1 && cao == '0 && cbo == '0, "R9 reset", rv(res), 0);
    repeat (2) @(negedge clk);
    aclr = 1'b0;

    // table walk, one vector per cycle (R1..R7, R3 second instance)
    for (int n = 0; n < N + 3; n++) begin
      @(negedge clk);
      if (n >= 3) begin
        v  = TBL[n-3];
        nx = (n - 2 < N) ? TBL[n-2] : z;
        e  = model(v, v.sub, v.ornd, f0, f1);
        check(rv(res) == e && s0 == f0 && s1 == f1, $sformatf("R%0d vector %0d", v.req, n-3),
              rv(res), e);
        e2 = model(v, nx.sub, nx.ornd, g0, g1);
        check(rv(res2) == e2 && s0b == g0 && s1b == g1,
              $sformatf("R3 one-deep control vector %0d", n-3), rv(res2), e2);
      end
      if (n < N) drive(TBL[n]); else drive(z);
    end

    // R8 shift chain
    @(negedge clk);
    csel = 1'b1; ca = 18'd11; cb = 18'd13; a0 = 18'd999; b0 = 18'd999; a1 = '0; b1 = '0;
    @(negedge clk);
    check(cao == 18'd11 && cbo == 18'd13, "R8 chain out", longint'(cao), 11);
    repeat (2) @(negedge clk);
    check(rv(res) == 143, "R8 chain operands", rv(res), 143);
    csel = 1'b0;

    // R10 freeze
    v = TBL[0]; drive(v);
    repeat (3) @(negedge clk);
    e = model(v, 1'b0, 1'b0, f0, f1);
    ena = 1'b0;
    drive(TBL[11]);
    repeat (4) @(negedge clk);
    check(rv(res) == e && cao == v.a0, "R10 hold", rv(res), e);
    ena = 1'b1;
    repeat (3) @(negedge clk);
    e = model(TBL[11], 1'b0, 1'b1, f0, f1);
    check(rv(res) == e, "R10 resume", rv(res), e);

    // R9 mid-run clear, sampled before any further edge
    drive(TBL[7]);
    repeat (3) @(negedge clk);
    check(s0 == 1'b1, "R5 flag before clear", longint'(s0), 1);
    aclr = 1'b1;
    #0.5;
    check(res == '0 && !s0 && !s1 && cao == '0, "R9 async clear", rv(res), 0);
    @(negedge clk);
    aclr = 1'b0;

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(4 * 200000);
    checks++; fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule